// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a video raster from timing values that software writes through a byte-wide register port. A pixel counter and a line counter walk the frame. Blanking comes first in each line and in each frame, in the order front porch, sync, back porch. Active video fills the end of the line and the end of the frame. The totals are not programmed. They are summed from the four component lengths on each axis.

Software stages a complete new timing set in shadow registers while the current frame runs. The whole set moves into use on the first pixel of the next frame, so no frame ever mixes old and new values. An external frame-sync pulse realigns the counters to a fixed reference position that is derived from the front porches. Two control bits invert the sync outputs for displays that expect active-low sync.

Top module: `vtg_raster`

## Requirements
- R1: The pixel counter runs from 0 to HT-1, where HT = h_front + h_sync + h_back + h_active. The line counter advances when the pixel counter wraps and runs from 0 to VT-1, where VT is summed the same way from the vertical values.
- R2: A synchronous active-high reset clears both counters to 0 and loads both the shadow and the active timing set with the parameter defaults.
- R3: Before inversion, hsync_o is high exactly when h_front <= pixel < h_front + h_sync.
- R4: Before inversion, vsync_o rises at line v_front, pixel h_front. It falls at line v_front + v_sync, pixel h_front. Both edges fall mid-line.
- R5: de_o is high exactly when pixel >= HT - h_active and line >= VT - v_active, so active video ends at the last pixel of the last line.
- R6: A frame_sync_i pulse sampled at a clock edge loads the pixel counter with h_front + 3 and the line counter with v_front + 1, using the active values. It takes priority over normal counting.
- R7: Control register address 16, bit 0, inverts hsync_o. Bit 1 of the same register inverts vsync_o.
- R8: Timing registers are 16 bits wide and are written as byte pairs. Field k uses address 2k for the high byte and 2k+1 for the low byte. The field order, k = 0 to 7, is h_front, h_sync, h_back, h_active, v_front, v_sync, v_back, v_active.
- R9: Writes land in shadow registers. The shadow set is copied into the active set only at the clock edge that leaves pixel HT-1 of line VT-1. A frame-sync pulse in that cycle suppresses the copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register byte address |
| wr_data_i | input | 8 | Register write data |
| frame_sync_i | input | 1 | Realign pulse from the incoming frame |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_o | output | 16 | Current pixel count |
| line_o | output | 16 | Current line count |

## Verification
The bench loads several timing sets while a frame is in progress. If a design applied writes at once, the line length would change partway through the frame and the pixel count would wrap at the wrong place. Vertical sync is compared on every cycle, which exposes a design that toggles it at pixel 0 instead of at pixel h_front. Data enable is checked in both the first and the last active line, which catches an off-by-one in the vertical window. A frame-sync pulse is placed exactly on the last pixel of the frame. A design that let the copy go ahead, or that let normal counting win over the reload, would show the wrong counters or the wrong sync widths afterwards.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int CW     = 16;
    localparam int AW     = 5;
    localparam int DW     = 8;
    localparam int NFIELD = 8;
    localparam int IDXW   = $clog2(NFIELD);

    localparam int IX_HFP  = 0;
    localparam int IX_HSW  = 1;
    localparam int IX_HBP  = 2;
    localparam int IX_HACT = 3;
    localparam int IX_VFP  = 4;
    localparam int IX_VSW  = 5;
    localparam int IX_VBP  = 6;
    localparam int IX_VACT = 7;

    localparam logic [AW-1:0] CTRL_ADDR = AW'(2 * NFIELD);

    typedef struct packed {
        logic [NFIELD-1:0][CW-1:0] f;
        logic                      h_inv;
        logic                      v_inv;
    } cfg_t;

    typedef struct packed {
        logic [CW-1:0] htot;
        logic [CW-1:0] vtot;
        logic [CW-1:0] hs_end;
        logic [CW-1:0] vs_end;
        logic [CW-1:0] de_h0;
        logic [CW-1:0] de_v0;
        logic [CW-1:0] ref_pix;
        logic [CW-1:0] ref_line;
    } lim_t;

    function automatic cfg_t make_cfg(int hfp, int hsw, int hbp, int hact,
                                      int vfp, int vsw, int vbp, int vact);
        cfg_t c;
        c.f[IX_HFP]  = CW'(hfp);
        c.f[IX_HSW]  = CW'(hsw);
        c.f[IX_HBP]  = CW'(hbp);
        c.f[IX_HACT] = CW'(hact);
        c.f[IX_VFP]  = CW'(vfp);
        c.f[IX_VSW]  = CW'(vsw);
        c.f[IX_VBP]  = CW'(vbp);
        c.f[IX_VACT] = CW'(vact);
        c.h_inv      = 1'b0;
        c.v_inv      = 1'b0;
        return c;
    endfunction

    function automatic lim_t derive(cfg_t c);
        lim_t l;
        l.htot     = c.f[IX_HFP] + c.f[IX_HSW] + c.f[IX_HBP] + c.f[IX_HACT];
        l.vtot     = c.f[IX_VFP] + c.f[IX_VSW] + c.f[IX_VBP] + c.f[IX_VACT];
        l.hs_end   = c.f[IX_HFP] + c.f[IX_HSW];
        l.vs_end   = c.f[IX_VFP] + c.f[IX_VSW];
        l.de_h0    = l.htot - c.f[IX_HACT];
        l.de_v0    = l.vtot - c.f[IX_VACT];
        l.ref_pix  = c.f[IX_HFP] + CW'(3);
        l.ref_line = c.f[IX_VFP] + CW'(1);
        return l;
    endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter cfg_t DEF = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    output cfg_t          act_cfg
);

    cfg_t            shd;
    logic            is_field;
    logic [IDXW-1:0] idx;

    assign is_field = wr_addr < AW'(2 * NFIELD);
    assign idx      = wr_addr[IDXW:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shd <= DEF;
        end else if (wr_en) begin
            if (wr_addr == CTRL_ADDR) begin
                shd.h_inv <= wr_data[0];
                shd.v_inv <= wr_data[1];
            end else if (is_field) begin
                if (!wr_addr[0])
                    shd.f[idx][CW-1 -: DW] <= wr_data;
                else
                    shd.f[idx][DW-1:0] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_cfg <= DEF;
        else if (commit)
            act_cfg <= shd;
    end

endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          fsync,
    input  lim_t          lim,
    output logic [CW-1:0] pix,
    output logic [CW-1:0] line,
    output logic          frame_end
);

    logic last_pix;
    logic last_line;

    assign last_pix  = pix == lim.htot - CW'(1);
    assign last_line = line == lim.vtot - CW'(1);
    assign frame_end = !fsync && last_pix && last_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix  <= '0;
            line <= '0;
        end else if (fsync) begin
            pix  <= lim.ref_pix;
            line <= lim.ref_line;
        end else if (last_pix) begin
            pix  <= '0;
            line <= last_line ? '0 : line + CW'(1);
        end else begin
            pix  <= pix + CW'(1);
        end
    end

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
    import vtg_pkg::*;
(
    input  logic [CW-1:0] pix,
    input  logic [CW-1:0] line,
    input  cfg_t          cfg,
    input  lim_t          lim,
    output logic          hsync,
    output logic          vsync,
    output logic          de
);

    logic hs_raw;
    logic vs_after;
    logic vs_before;
    logic h_win;
    logic v_win;

    always_comb begin
        hs_raw    = (pix >= cfg.f[IX_HFP]) && (pix < lim.hs_end);
        vs_after  = (line > cfg.f[IX_VFP]) ||
                    ((line == cfg.f[IX_VFP]) && (pix >= cfg.f[IX_HFP]));
        vs_before = (line < lim.vs_end) ||
                    ((line == lim.vs_end) && (pix < cfg.f[IX_HFP]));
        h_win     = pix >= lim.de_h0;
        v_win     = line >= lim.de_v0;
        hsync     = hs_raw ^ cfg.h_inv;
        vsync     = (vs_after && vs_before) ^ cfg.v_inv;
        de        = h_win && v_win;
    end

endmodule

// File: rtl/vtg_raster.sv
module vtg_raster
    import vtg_pkg::*;
#(
    parameter int DEF_HFP  = 2,
    parameter int DEF_HSW  = 2,
    parameter int DEF_HBP  = 2,
    parameter int DEF_HACT = 8,
    parameter int DEF_VFP  = 1,
    parameter int DEF_VSW  = 1,
    parameter int DEF_VBP  = 1,
    parameter int DEF_VACT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          frame_sync_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [CW-1:0] pix_o,
    output logic [CW-1:0] line_o
);

    localparam cfg_t DEF_CFG = make_cfg(DEF_HFP, DEF_HSW, DEF_HBP, DEF_HACT,
                                        DEF_VFP, DEF_VSW, DEF_VBP, DEF_VACT);

    cfg_t act_cfg;
    lim_t lim;
    logic frame_end;

    assign lim = derive(act_cfg);

    vtg_regs #(.DEF(DEF_CFG)) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .commit  (frame_end),
        .act_cfg (act_cfg)
    );

    vtg_counter i_cnt (
        .clk       (clk),
        .rst       (rst),
        .fsync     (frame_sync_i),
        .lim       (lim),
        .pix       (pix_o),
        .line      (line_o),
        .frame_end (frame_end)
    );

    vtg_decode i_dec (
        .pix   (pix_o),
        .line  (line_o),
        .cfg   (act_cfg),
        .lim   (lim),
        .hsync (hsync_o),
        .vsync (vsync_o),
        .de    (de_o)
    );

endmodule

// File: rtl/vtg_raster_chk.sv
module vtg_raster_chk
    import vtg_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          fsync,
    input logic [CW-1:0] pix,
    input logic [CW-1:0] line,
    input logic          hsync,
    input logic          de,
    input cfg_t          act,
    input lim_t          lim,
    input logic          frame_end
);

    // R1: wrap after the last pixel of a line
    p_pix_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (!fsync && pix == lim.htot - CW'(1)) |=> (pix == '0));

    // R1: plain step inside a line
    p_pix_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!fsync && pix != lim.htot - CW'(1)) |=> (pix == $past(pix) + CW'(1)));

    // R2: counters leave reset at origin
    p_reset_origin_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pix == '0 && line == '0));

    // R5: active video never overlaps the horizontal sync pulse
    p_de_clear_of_sync_r5: assert property (@(posedge clk) disable iff (rst)
        de |-> ((hsync ^ act.h_inv) == 1'b0));

    // R6: realign lands on the reference position
    p_realign_r6: assert property (@(posedge clk) disable iff (rst)
        fsync |=> (pix == $past(lim.ref_pix) && line == $past(lim.ref_line)));

    // R9: active timing holds except across a frame boundary
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(act));

endmodule

bind vtg_raster vtg_raster_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .fsync     (frame_sync_i),
    .pix       (pix_o),
    .line      (line_o),
    .hsync     (hsync_o),
    .de        (de_o),
    .act       (act_cfg),
    .lim       (lim),
    .frame_end (frame_end)
);

// File: tb/test_vtg_raster.sv
`timescale 1ns/1ps
module test_vtg_raster;

    localparam int NCFG = 4;
    // h_front, h_sync, h_back, h_active, v_front, v_sync, v_back, v_active, h_inv, v_inv
    localparam int CFG [NCFG][10] = '{
        '{1, 2, 1, 4, 1, 1, 1, 2, 0, 0},
        '{3, 1, 2, 5, 2, 2, 1, 3, 1, 0},
        '{2, 3, 1, 6, 1, 2, 2, 4, 0, 1},
        '{4, 2, 3, 3, 2, 1, 1, 2, 1, 1}
    };
    localparam int DEF [8] = '{2, 2, 2, 8, 1, 1, 1, 3};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        fsync = 1'b0;
    logic        hsync, vsync, de;
    logic [15:0] pix, line;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    mon_on = 1'b0;
    string tag = "R2";

    // reference model state
    int mf [8];
    int sf [8];
    int osf [8];
    int mh, mv, sh, sv, osh, osv;
    int mp, ml, ht, vt;
    bit fe;

    always #2.5 clk = ~clk;

    vtg_raster i_vtg_raster (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .frame_sync_i (fsync),
        .hsync_o      (hsync),
        .vsync_o      (vsync),
        .de_o         (de),
        .pix_o        (pix),
        .line_o       (line)
    );

    always @(posedge clk) begin
        if (rst) begin
            mp = 0; ml = 0; mh = 0; mv = 0; sh = 0; sv = 0;
            for (int k = 0; k < 8; k++) begin mf[k] = DEF[k]; sf[k] = DEF[k]; end
        end else begin
            ht = mf[0] + mf[1] + mf[2] + mf[3];
            vt = mf[4] + mf[5] + mf[6] + mf[7];
            fe = !fsync && mp == ht - 1 && ml == vt - 1;
            for (int k = 0; k < 8; k++) osf[k] = sf[k];
            osh = sh; osv = sv;
            if (wr_en) begin
                if (wr_addr == 5'd16) begin
                    sh = int'(wr_data[0]); sv = int'(wr_data[1]);
                end else if (wr_addr < 5'd16) begin
                    if (!wr_addr[0]) sf[wr_addr >> 1] = (int'(wr_data) << 8) | (sf[wr_addr >> 1] & 255);
                    else             sf[wr_addr >> 1] = (sf[wr_addr >> 1] & 'hff00) | int'(wr_data);
                end
            end
            if (fsync) begin
                mp = mf[0] + 3; ml = mf[4] + 1;
            end else if (mp == ht - 1) begin
                mp = 0; ml = (ml == vt - 1) ? 0 : ml + 1;
            end else begin
                mp = mp + 1;
            end
            if (fe) begin
                for (int k = 0; k < 8; k++) mf[k] = osf[k];
                mh = osh; mv = osv;
            end
        end
    end

    function automatic bit exp_hs();
        return ((mp >= mf[0] && mp < mf[0] + mf[1]) ? 1'b1 : 1'b0) ^ mh[0];
    endfunction

    function automatic bit exp_vs();
        int vse;
        bit aft, bef;
        vse = mf[4] + mf[5];
        aft = ml > mf[4] || (ml == mf[4] && mp >= mf[0]);
        bef = ml < vse || (ml == vse && mp < mf[0]);
        return (aft && bef) ^ mv[0];
    endfunction

    function automatic bit exp_de();
        int t_h, t_v;
        t_h = mf[0] + mf[1] + mf[2] + mf[3];
        t_v = mf[4] + mf[5] + mf[6] + mf[7];
        return mp >= t_h - mf[3] && ml >= t_v - mf[7];
    endfunction

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (mon_on) begin
            n_vec++;
            if (int'(pix) != mp || int'(line) != ml || hsync != exp_hs() ||
                vsync != exp_vs() || de != exp_de()) begin
                n_bad++;
                $display("FAIL %s (R1/R3/R4/R5/R7): pix=%0d/%0d line=%0d/%0d hs=%b/%b vs=%b/%b de=%b/%b",
                         tag, pix, mp, line, ml, hsync, exp_hs(), vsync, exp_vs(), de, exp_de());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int c);
        for (int k = 0; k < 8; k++) begin
            wr(5'(2 * k), 8'(CFG[c][k] >> 8));
            wr(5'(2 * k + 1), 8'(CFG[c][k]));
        end
        wr(5'd16, {6'b0, 1'(CFG[c][9]), 1'(CFG[c][8])});
    endtask

    task automatic direct(input bit ok, input string rq, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: origin and quiet outputs with default timing
        direct(pix == 0 && line == 0, "R2 counters", int'(pix) + int'(line), 0);
        direct(!hsync && !vsync && !de, "R2 outputs", int'({hsync, vsync, de}), 0);
        mon_on = 1'b1;
        tag = "R1 default";
        repeat (200) @(negedge clk);

        for (int c = 0; c < NCFG; c++) begin
            // R8, R9: staged load while a frame is running
            tag = "R8/R9 load";
            load(c);
            tag = "R1/R3/R4/R5/R7 run";
            repeat (300) @(negedge clk);
            // R6: mid-frame realign
            tag = "R6 realign";
            fsync = 1'b1;
            @(negedge clk);
            fsync = 1'b0;
            direct(int'(pix) == CFG[c][0] + 3, "R6 pixel", int'(pix), CFG[c][0] + 3);
            direct(int'(line) == CFG[c][4] + 1, "R6 line", int'(line), CFG[c][4] + 1);
            repeat (250) @(negedge clk);
        end

        // R9: realign on the last pixel of the frame suppresses the copy
        tag = "R9 boundary";
        wr(5'd1, 8'd5);
        while (!(int'(pix) == ht - 1 && int'(line) == vt - 1)) @(negedge clk);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        direct(int'(pix) == CFG[NCFG-1][0] + 3, "R9 no commit under realign", int'(pix), CFG[NCFG-1][0] + 3);
        repeat (300) @(negedge clk);

        mon_on = 1'b0;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule